// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block is the operating-mode state machine at the top of a CAN protocol controller. It holds one of five modes: initialization (the reset mode), normal running, sleep, interface sleep with the protocol clock stopped, and bus-off. It moves between them in response to the chip reset, four software control levels, status from the frame transmitter, the transmit error count, and the bus level sampled once per bit time.

The rest of the controller reads the mode and the flags derived from it. The register file uses `regs_locked` to refuse CPU writes to the identifier, message-control, interrupt-control, status and error-counter registers. It uses the one-cycle `clr_pulse` to wipe those same registers whenever initialization mode is entered. Control, configuration and mask registers are left alone. The bit engine may drive or sample the bus only while `bus_active` is high. The clock gate for the protocol logic follows `proto_clk_en`.

All control and status pins are plain levels; no data streams through this block, so it has no handshake. Mode changes take effect on the clock edge after the qualifying input is seen. The chip reset is asynchronous and active low.

Top module: `can_mode_seq`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (initialization) at once, without waiting for a clock edge, and `clr_pulse` is 0. Reset has priority over every other input.
- R2: In running mode (1) with `tx_busy` low, a high `sw_reset_req` moves `mode` to 0 at the next edge. In bus-off mode (4), a high `sw_reset_req` without `force_recover` also moves `mode` to 0.
- R3: In running mode, while `tx_busy` is high and none of `tx_done`, `tx_arb_lost` or `tx_err` is high, `sw_reset_req` is held off and `mode` stays 1. Any one of those three end events lets the request through at the next edge.
- R4: In mode 0, a high `sleep_req` enters sleep mode (2), and this takes priority over leaving initialization. Otherwise a low `sw_reset_req` enters running mode (1).
- R5: In mode 2, a high `clkstop_req` enters interface sleep (3), and a low `sleep_req` returns to 0. In mode 3, a low `clkstop_req` returns to 2. `proto_clk_en` is 0 only in mode 3.
- R6: In running mode, a `tec` value above 255 enters bus-off (4) at the next edge, unless a reset request is admitted in that cycle. A `tec` of exactly 255 does not. `st_busoff` is 1 only in mode 4.
- R7: In bus-off, `bus_bit` is sampled on each `bit_strobe`, with 1 meaning recessive. Each run of 11 consecutive recessive samples counts one occurrence. A dominant sample restarts the run. `mode` becomes 1 on the edge after the 128th occurrence is counted.
- R8: In bus-off, a high `force_recover` moves `mode` to 1 at the next edge, with priority over `sw_reset_req`.
- R9: The run and occurrence counts restart from zero at every entry to bus-off. Occurrences counted during an earlier bus-off episode do not carry over.
- R10: `clr_pulse` is high for exactly the first cycle of each entry into mode 0 from another mode. `regs_locked` and `st_reset` are 1 exactly while `mode` is 0.
- R11: `bus_active` is 1 only in modes 1 and 4. It is 0 in initialization, sleep and interface sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| sw_reset_req | input | 1 | Software request for initialization mode (level) |
| sleep_req | input | 1 | Software request for sleep mode (level) |
| clkstop_req | input | 1 | Software request to stop the protocol clock (level) |
| force_recover | input | 1 | Forces an immediate return from bus-off |
| tx_busy | input | 1 | Transmitter is sending a frame |
| tx_done | input | 1 | Transmission completed this cycle |
| tx_arb_lost | input | 1 | Arbitration was lost this cycle |
| tx_err | input | 1 | Transmit error detected this cycle |
| tec | input | TEC_W (9) | Transmit error counter value |
| bus_bit | input | 1 | Sampled bus level, 1 = recessive |
| bit_strobe | input | 1 | One-cycle strobe per bit time |
| mode | output | 3 | 0 init, 1 running, 2 sleep, 3 interface sleep, 4 bus-off |
| st_reset | output | 1 | Initialization-mode status flag |
| st_busoff | output | 1 | Bus-off status flag |
| regs_locked | output | 1 | Blocks CPU writes to the cleared register group |
| clr_pulse | output | 1 | One-cycle clear of the status and counter register group |
| proto_clk_en | output | 1 | Enable for the protocol clock gate |
| bus_active | output | 1 | Bus communication permitted |

## Verification
The hardest situation to reach from the ports is the counter restart at bus-off entry (R9). It only shows when a second bus-off episode would end too early if counts from the first episode survived. The stimulus drives a first bus-off and feeds 60 full recessive runs into it, then forces a return and raises `tec` again. It then feeds 127 runs and shows the block still in bus-off before the final run releases it. A separate episode breaks a run with a dominant bit just before the 128th occurrence, so that a run count that is not restarted would release the block one run early.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MD_INIT    = 3'd0,
    MD_RUN     = 3'd1,
    MD_SLEEP   = 3'd2,
    MD_IFSLEEP = 3'd3,
    MD_BUSOFF  = 3'd4
  } can_mode_e;
endpackage

// File: rtl/can_busoff_recov.sv
// Counts runs of recessive bits while bus-off; raises done when enough runs seen.
module can_busoff_recov #(
  parameter int RUN_LEN    = 11,
  parameter int OCC_TARGET = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bus_bit,
  input  logic bit_strobe,
  output logic done
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int OW = $clog2(OCC_TARGET + 1);

  logic [RW-1:0] run_q;
  logic [OW-1:0] occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (!active) begin
      run_q <= '0;
      occ_q <= '0;
    end else if (bit_strobe && !done) begin
      if (!bus_bit) begin
        run_q <= '0;
      end else if (run_q == RW'(RUN_LEN - 1)) begin
        run_q <= '0;
        occ_q <= occ_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign done = (occ_q == OW'(OCC_TARGET));
endmodule

// File: rtl/can_mode_fsm.sv
// Mode state register, next-state priority logic and the entry clear pulse.
module can_mode_fsm
  import can_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sw_reset_req,
  input  logic      sleep_req,
  input  logic      clkstop_req,
  input  logic      force_recover,
  input  logic      tx_busy,
  input  logic      tx_done,
  input  logic      tx_arb_lost,
  input  logic      tx_err,
  input  logic      tec_over,
  input  logic      recov_done,
  output can_mode_e mode_q,
  output logic      clr_q
);
  can_mode_e mode_d;
  logic      tx_clear;

  // A frame in flight blocks the reset request until it ends one way or another.
  assign tx_clear = !tx_busy || tx_done || tx_arb_lost || tx_err;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_INIT: begin
        if (sleep_req)          mode_d = MD_SLEEP;
        else if (!sw_reset_req) mode_d = MD_RUN;
      end
      MD_SLEEP: begin
        if (clkstop_req)        mode_d = MD_IFSLEEP;
        else if (!sleep_req)    mode_d = MD_INIT;
      end
      MD_IFSLEEP: begin
        if (!clkstop_req)       mode_d = MD_SLEEP;
      end
      MD_RUN: begin
        if (sw_reset_req && tx_clear) mode_d = MD_INIT;
        else if (tec_over)            mode_d = MD_BUSOFF;
      end
      MD_BUSOFF: begin
        if (force_recover)      mode_d = MD_RUN;
        else if (sw_reset_req)  mode_d = MD_INIT;
        else if (recov_done)    mode_d = MD_RUN;
      end
      default:                  mode_d = MD_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_INIT;
      clr_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      clr_q  <= (mode_d == MD_INIT) && (mode_q != MD_INIT);
    end
  end
endmodule

// File: rtl/can_mode_seq.sv
// Top: CAN controller operating-mode sequencer.
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int TEC_W      = 9,
  parameter int TEC_LIMIT  = 255,
  parameter int RUN_LEN    = 11,
  parameter int OCC_TARGET = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_reset_req,
  input  logic             sleep_req,
  input  logic             clkstop_req,
  input  logic             force_recover,
  input  logic             tx_busy,
  input  logic             tx_done,
  input  logic             tx_arb_lost,
  input  logic             tx_err,
  input  logic [TEC_W-1:0] tec,
  input  logic             bus_bit,
  input  logic             bit_strobe,
  output logic [2:0]       mode,
  output logic             st_reset,
  output logic             st_busoff,
  output logic             regs_locked,
  output logic             clr_pulse,
  output logic             proto_clk_en,
  output logic             bus_active
);
  can_mode_e mode_q;
  logic      tec_over;
  logic      recov_done;

  assign tec_over = (tec > TEC_W'(TEC_LIMIT));

  can_mode_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_reset_req  (sw_reset_req),
    .sleep_req     (sleep_req),
    .clkstop_req   (clkstop_req),
    .force_recover (force_recover),
    .tx_busy       (tx_busy),
    .tx_done       (tx_done),
    .tx_arb_lost   (tx_arb_lost),
    .tx_err        (tx_err),
    .tec_over      (tec_over),
    .recov_done    (recov_done),
    .mode_q        (mode_q),
    .clr_q         (clr_pulse)
  );

  can_busoff_recov #(
    .RUN_LEN    (RUN_LEN),
    .OCC_TARGET (OCC_TARGET)
  ) u_recov (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (mode_q == MD_BUSOFF),
    .bus_bit    (bus_bit),
    .bit_strobe (bit_strobe),
    .done       (recov_done)
  );

  assign mode         = mode_q;
  assign st_reset     = (mode_q == MD_INIT);
  assign regs_locked  = (mode_q == MD_INIT);
  assign st_busoff    = (mode_q == MD_BUSOFF);
  assign proto_clk_en = (mode_q != MD_IFSLEEP);
  assign bus_active   = (mode_q == MD_RUN) || (mode_q == MD_BUSOFF);
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk #(
  parameter int TEC_W     = 9,
  parameter int TEC_LIMIT = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_reset_req,
  input logic             sleep_req,
  input logic             clkstop_req,
  input logic             force_recover,
  input logic             tx_busy,
  input logic             tx_done,
  input logic             tx_arb_lost,
  input logic             tx_err,
  input logic [TEC_W-1:0] tec,
  input logic [2:0]       mode,
  input logic             clr_pulse,
  input logic             proto_clk_en,
  input logic             bus_active
);
  always @(posedge clk) begin
    if (!rst_n) AST_RESET_INIT: assert (mode == 3'd0 && !clr_pulse); // R1
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= 3'd4); // R11

  AST_TX_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && sw_reset_req && tx_busy && !tx_done && !tx_arb_lost && !tx_err
     && tec <= TEC_W'(TEC_LIMIT)) |=> mode == 3'd1); // R3

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && sleep_req) |=> mode == 3'd2); // R4

  AST_BUSOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && !sw_reset_req && tec > TEC_W'(TEC_LIMIT)) |=> mode == 3'd4); // R6

  AST_FORCE_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && force_recover) |=> mode == 3'd1); // R8

  AST_CLEAR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'd0) |=> (clr_pulse == (mode == 3'd0))); // R10

  AST_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse); // R10

  AST_CLOCK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> !proto_clk_en); // R5

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd2 || mode == 3'd3) |-> !bus_active); // R11
endmodule

bind can_mode_seq can_mode_chk #(.TEC_W(TEC_W), .TEC_LIMIT(TEC_LIMIT)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_reset_req  (sw_reset_req),
  .sleep_req     (sleep_req),
  .clkstop_req   (clkstop_req),
  .force_recover (force_recover),
  .tx_busy       (tx_busy),
  .tx_done       (tx_done),
  .tx_arb_lost   (tx_arb_lost),
  .tx_err        (tx_err),
  .tec           (tec),
  .mode          (mode),
  .clr_pulse     (clr_pulse),
  .proto_clk_en  (proto_clk_en),
  .bus_active    (bus_active)
);

// File: tb/tb_can_mode_seq.sv
`timescale 1ns/1ps
module tb_can_mode_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sw_reset_req, sleep_req, clkstop_req, force_recover;
  logic       tx_busy, tx_done, tx_arb_lost, tx_err;
  logic [8:0] tec;
  logic       bus_bit, bit_strobe;
  logic [2:0] mode;
  logic       st_reset, st_busoff, regs_locked, clr_pulse, proto_clk_en, bus_active;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  can_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .sw_reset_req(sw_reset_req), .sleep_req(sleep_req),
    .clkstop_req(clkstop_req), .force_recover(force_recover), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_arb_lost(tx_arb_lost), .tx_err(tx_err), .tec(tec),
    .bus_bit(bus_bit), .bit_strobe(bit_strobe), .mode(mode), .st_reset(st_reset),
    .st_busoff(st_busoff), .regs_locked(regs_locked), .clr_pulse(clr_pulse),
    .proto_clk_en(proto_clk_en), .bus_active(bus_active)
  );

  // Vector: {sw, slp, cstop, force, busy, done, arb, err, tec_over, clr_exp, mode_exp[2:0]}
  localparam int NV = 22;
  localparam logic [12:0] VEC [0:NV-1] = '{
    13'b1_0_0_0_0_0_0_0_0_0_000, // R4 hold init
    13'b1_1_0_0_0_0_0_0_0_0_010, // R4 sleep
    13'b1_1_1_0_0_0_0_0_0_0_011, // R5 interface sleep
    13'b1_1_0_0_0_0_0_0_0_0_010, // R5 back to sleep
    13'b1_0_0_0_0_0_0_0_0_1_000, // R5 back to init, R10 clear
    13'b0_0_0_0_0_0_0_0_0_0_001, // R4 run
    13'b1_0_0_0_1_0_0_0_0_0_001, // R3 held
    13'b1_0_0_0_1_0_0_0_0_0_001, // R3 held
    13'b1_0_0_0_1_1_0_0_0_1_000, // R3 done
    13'b0_0_0_0_0_0_0_0_0_0_001,
    13'b1_0_0_0_1_0_1_0_0_1_000, // R3 arbitration lost
    13'b0_0_0_0_0_0_0_0_0_0_001,
    13'b1_0_0_0_1_0_0_1_0_1_000, // R3 error
    13'b0_0_0_0_0_0_0_0_0_0_001,
    13'b0_0_0_0_0_0_0_0_1_0_100, // R6 bus-off
    13'b0_0_0_1_0_0_0_0_1_0_001, // R8 forced return
    13'b0_0_0_0_0_0_0_0_1_0_100, // R6
    13'b1_0_0_0_0_0_0_0_0_1_000, // R2 reset from bus-off
    13'b0_0_0_0_0_0_0_0_0_0_001,
    13'b0_0_0_0_0_0_0_0_1_0_100, // R6
    13'b1_0_0_1_0_0_0_0_0_0_001, // R8 priority over reset
    13'b1_0_0_0_0_0_0_0_1_1_000  // R2 reset wins over tec in run
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_flags(input int m);
    check("R10 lock", regs_locked, (m == 0));
    check("R10 st_reset", st_reset, (m == 0));
    check("R6 st_busoff", st_busoff, (m == 4));
    check("R5 clk_en", proto_clk_en, (m != 3));
    check("R11 bus_active", bus_active, (m == 1 || m == 4));
  endtask

  task automatic send_bit(input logic b);
    bus_bit = b;
    bit_strobe = 1'b1;
    step();
    bit_strobe = 1'b0;
  endtask

  task automatic send_runs(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 11; k++) send_bit(1'b1);
  endtask

  task automatic enter_busoff();
    tec = 9'd300;
    step();
    tec = 9'd0;
    check("R6 enter bus-off", mode, 4);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_reset_req = 1'b1; sleep_req = 1'b0; clkstop_req = 1'b0; force_recover = 1'b0;
    tx_busy = 1'b0; tx_done = 1'b0; tx_arb_lost = 1'b0; tx_err = 1'b0;
    tec = 9'd0; bus_bit = 1'b1; bit_strobe = 1'b0;
    step(); step();
    check("R1 reset mode", mode, 0);
    check("R1 reset clr", clr_pulse, 0);
    check_flags(0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      {sw_reset_req, sleep_req, clkstop_req, force_recover,
       tx_busy, tx_done, tx_arb_lost, tx_err} = VEC[i][12:5];
      tec = VEC[i][4] ? 9'd300 : 9'd0;
      step();
      check("R2-vector mode", mode, int'(VEC[i][2:0]));
      check("R10 clr", clr_pulse, int'(VEC[i][3]));
      check_flags(int'(VEC[i][2:0]));
    end
    {sw_reset_req, sleep_req, clkstop_req, force_recover,
     tx_busy, tx_done, tx_arb_lost, tx_err} = '0;
    tec = 9'd0;
    step();
    check("R4 run", mode, 1);

    // R6 boundary: 255 does not trip bus-off
    tec = 9'd255;
    step(); step();
    check("R6 tec 255 stays", mode, 1);
    tec = 9'd0;

    // R1: asynchronous CPU reset from running mode
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", mode, 0);
    check("R1 no clr", clr_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    check("R4 run after reset", mode, 1);

    // R7: recovery with a dominant bit breaking a run
    enter_busoff();
    send_runs(127);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    send_bit(1'b0);
    for (int k = 0; k < 10; k++) send_bit(1'b1);
    step();
    check("R7 still bus-off after broken run", mode, 4);
    send_bit(1'b1);
    check("R7 one cycle before release", mode, 4);
    step();
    check("R7 released", mode, 1);

    // R9: counts from an earlier episode do not carry over
    enter_busoff();
    send_runs(60);
    force_recover = 1'b1;
    step();
    force_recover = 1'b0;
    check("R8 forced return", mode, 1);
    enter_busoff();
    send_runs(127);
    step();
    check("R9 no carry-over", mode, 4);
    send_runs(1);
    step();
    check("R9 release after full count", mode, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule